// File: doc/BRIEF.md
# Video Fetch Address Generator

This block turns a text-mode video controller's fetch requests into memory addresses. Three kinds of configuration feed it: a 2-bit bank select coming from an I/O port, a base register that places the screen matrix and the character set inside the current bank, and two control bits. One control bit relocates the character ROM glyphs; the other selects 40- or 80-column layout. The layout bit also moves the sprite pointer table.

A request names a fetch kind together with the column, row, screen code, glyph row and sprite index. The block answers with a 16-bit address and a flag. The flag says whether the glyph data comes from character ROM or from work RAM. Requests and responses are valid/ready streams. A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output register is empty or the consumer takes its response in the same cycle. A response stays valid, with address and flag unchanged, until `rsp_ready` is high. Configuration writes are single-cycle strobes and are not flow-controlled.

Top module: `vfa_top`

## Requirements
- R1: After reset, `rsp_valid` is 0, `req_ready` is 1, and the bank base, screen offset, character offset and both control bits are all zero.
- R2: A write to the bank port sets the bank base to the bitwise inverse of `bank_sel`, placed at address bits 15:14, which gives 16 KB banks.
- R3: A screen fetch (kind 0) returns ((column + row × columns) masked to 14 bits) OR screen offset OR bank base. The screen offset is `base_scr` × 1 KB.
- R4: The column count is 40 while the layout bit (`cols_wide`) is 0, and 80 while it is 1.
- R5: A glyph fetch (kind 1) uses character ROM (`rsp_rom`=1) when character-offset bits 13:12 are 01 and bank-base bit 14 is 0. The character offset is `base_chr` × 2 KB. The address is then (0x9000 if `crom_hi` is 1, else 0xD000) + (character offset bit 11 × 0x800) + ((code × 8 + glyph row) masked to 14 bits).
- R6: In every other case, a glyph fetch returns (character offset OR bank base) + ((code × 8 + glyph row) masked to 14 bits), with `rsp_rom`=0.
- R7: A sprite-pointer fetch (kind 2) returns ((screen offset + table offset + sprite index) masked to 14 bits) OR bank base. The table offset is 0x3F8 in 40-column layout and 0x7F8 in 80-column layout.
- R8: A sprite-data fetch (kind 3) takes `req_code` as the sprite pointer and `req_col` bits 5:0 as the byte offset. It returns ((pointer × 64 + offset) masked to 14 bits) OR bank base.
- R9: An accepted request gives a valid response on the next cycle. The output empties when the consumer takes a response and no new request is accepted in that cycle.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, the response holds steady and `req_ready` is 0.
- R11: A configuration write takes effect one cycle after its strobe. A request accepted in the same cycle as a write uses the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_wr | input | 1 | Bank port write strobe |
| bank_sel | input | 2 | Bank port value |
| base_wr | input | 1 | Base register write strobe |
| base_scr | input | 4 | Screen base field, 1 KB units |
| base_chr | input | 3 | Character base field, 2 KB units |
| crom_wr | input | 1 | Character ROM placement write strobe |
| crom_hi | input | 1 | 1 puts the ROM glyphs at 0x9000, 0 at 0xD000 |
| cols_wr | input | 1 | Layout write strobe |
| cols_wide | input | 1 | 1 selects 80 columns |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_kind | input | 2 | 0 screen, 1 glyph, 2 sprite pointer, 3 sprite data |
| req_col | input | 7 | Column, or sprite byte offset for kind 3 |
| req_row | input | 5 | Character row |
| req_code | input | 8 | Screen code, or sprite pointer for kind 3 |
| req_grow | input | 3 | Glyph row within the character |
| req_spr | input | 3 | Sprite index |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_addr | output | 16 | Resolved fetch address |
| rsp_rom | output | 1 | 1 when the address is in character ROM |

## Verification
The stream assertions assume the consumer's `rsp_ready` is a clean level in every cycle after reset. They also assume the configuration strobes are never unknown. The stimulus drives every input from time zero and only changes it between clock edges, so those assumptions always hold. The bench keeps columns below 80 and rows below 25, which is the only range the layout math is meant to cover. The ROM-range assertion depends on the configured bases staying inside the two ROM windows. The bench toggles `rsp_ready` randomly so that stalls happen with writes and requests in flight, and every stall takes place inside that legal envelope.

// File: rtl/vfa_pkg.sv
package vfa_pkg;
  typedef enum logic [1:0] {
    FK_SCREEN = 2'd0,
    FK_GLYPH  = 2'd1,
    FK_SPTR   = 2'd2,
    FK_SDATA  = 2'd3
  } fetch_kind_e;
endpackage

// File: rtl/vfa_cfg.sv
module vfa_cfg #(
  parameter int OFS_W = 14,
  parameter int SCR_W = 4,
  parameter int CHR_W = 3,
  localparam int ADDR_W = OFS_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_wr,
  input  logic [1:0]        bank_sel,
  input  logic              base_wr,
  input  logic [SCR_W-1:0]  base_scr,
  input  logic [CHR_W-1:0]  base_chr,
  input  logic              crom_wr,
  input  logic              crom_hi,
  input  logic              cols_wr,
  input  logic              cols_wide,
  output logic [ADDR_W-1:0] bank_base,
  output logic [OFS_W-1:0]  scr_off,
  output logic [OFS_W-1:0]  chr_off,
  output logic              rom_hi,
  output logic              wide
);
  localparam int SCR_SH = OFS_W - SCR_W;
  localparam int CHR_SH = OFS_W - CHR_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_base <= '0;
      scr_off   <= '0;
      chr_off   <= '0;
      rom_hi    <= 1'b0;
      wide      <= 1'b0;
    end else begin
      if (bank_wr) bank_base <= {~bank_sel, {OFS_W{1'b0}}};
      if (base_wr) begin
        scr_off <= {base_scr, {SCR_SH{1'b0}}};
        chr_off <= {base_chr, {CHR_SH{1'b0}}};
      end
      if (crom_wr) rom_hi <= crom_hi;
      if (cols_wr) wide   <= cols_wide;
    end
  end

  p_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bank_wr |=> bank_base[ADDR_W-1:OFS_W] == ~$past(bank_sel));
  p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!bank_wr && !base_wr) |=> ($stable(bank_base) && $stable(scr_off) && $stable(chr_off)));
endmodule

// File: rtl/vfa_addr.sv
module vfa_addr
  import vfa_pkg::*;
#(
  parameter int OFS_W      = 14,
  parameter int COL_W      = 7,
  parameter int ROW_W      = 5,
  parameter int CODE_W     = 8,
  parameter int GROW_W     = 3,
  parameter int SPR_W      = 3,
  parameter int COLS_NARROW = 40,
  parameter int COLS_WIDE   = 80,
  parameter int PTR_NARROW  = 'h3F8,
  parameter int PTR_WIDE    = 'h7F8,
  parameter int ROM_LOW     = 'h9000,
  parameter int ROM_HIGH    = 'hD000,
  localparam int ADDR_W = OFS_W + 2
) (
  input  logic [ADDR_W-1:0] bank_base,
  input  logic [OFS_W-1:0]  scr_off,
  input  logic [OFS_W-1:0]  chr_off,
  input  logic              rom_hi,
  input  logic              wide,
  input  logic [1:0]        kind,
  input  logic [COL_W-1:0]  col,
  input  logic [ROW_W-1:0]  row,
  input  logic [CODE_W-1:0] code,
  input  logic [GROW_W-1:0] grow,
  input  logic [SPR_W-1:0]  spr,
  output logic [ADDR_W-1:0] addr,
  output logic              rom
);
  localparam int SD_SH = 6;

  logic [OFS_W-1:0]  lin, gidx, sptr, sdat;
  logic [ADDR_W-1:0] rom_base;
  logic              use_rom;

  always_comb begin
    lin  = OFS_W'(col) + OFS_W'(row) *
           (wide ? OFS_W'(COLS_WIDE) : OFS_W'(COLS_NARROW));
    gidx = OFS_W'({code, {GROW_W{1'b0}}}) + OFS_W'(grow);
    sptr = scr_off + (wide ? OFS_W'(PTR_WIDE) : OFS_W'(PTR_NARROW)) + OFS_W'(spr);
    sdat = OFS_W'({code, {SD_SH{1'b0}}}) + OFS_W'(col[SD_SH-1:0]);
    use_rom  = (chr_off[OFS_W-1:OFS_W-2] == 2'b01) && !bank_base[OFS_W];
    rom_base = rom_hi ? ADDR_W'(ROM_LOW) : ADDR_W'(ROM_HIGH);
    rom  = 1'b0;
    addr = '0;
    case (fetch_kind_e'(kind))
      FK_SCREEN: addr = bank_base | ADDR_W'(scr_off) | ADDR_W'(lin);
      FK_GLYPH: begin
        if (use_rom) begin
          rom  = 1'b1;
          addr = rom_base + ADDR_W'({chr_off[OFS_W-3], {(OFS_W-3){1'b0}}}) + ADDR_W'(gidx);
        end else begin
          addr = (bank_base | ADDR_W'(chr_off)) + ADDR_W'(gidx);
        end
      end
      FK_SPTR:  addr = bank_base | ADDR_W'(sptr);
      default:  addr = bank_base | ADDR_W'(sdat);
    endcase
  end
endmodule

// File: rtl/vfa_out.sv
module vfa_out #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_rom,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_rom
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_rom   <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_addr <= in_addr;
        out_rom  <= in_rom;
      end
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_rom)));
  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);
endmodule

// File: rtl/vfa_top.sv
module vfa_top #(
  parameter int OFS_W  = 14,
  parameter int COL_W  = 7,
  parameter int ROW_W  = 5,
  parameter int CODE_W = 8,
  parameter int GROW_W = 3,
  parameter int SPR_W  = 3,
  localparam int ADDR_W = OFS_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_wr,
  input  logic [1:0]        bank_sel,
  input  logic              base_wr,
  input  logic [3:0]        base_scr,
  input  logic [2:0]        base_chr,
  input  logic              crom_wr,
  input  logic              crom_hi,
  input  logic              cols_wr,
  input  logic              cols_wide,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [COL_W-1:0]  req_col,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [CODE_W-1:0] req_code,
  input  logic [GROW_W-1:0] req_grow,
  input  logic [SPR_W-1:0]  req_spr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_rom
);
  logic [ADDR_W-1:0] bank_base, calc_addr;
  logic [OFS_W-1:0]  scr_off, chr_off;
  logic              rom_hi, wide, calc_rom;

  vfa_cfg #(.OFS_W(OFS_W), .SCR_W(4), .CHR_W(3)) i_cfg (
    .clk, .rst_n, .bank_wr, .bank_sel, .base_wr, .base_scr, .base_chr,
    .crom_wr, .crom_hi, .cols_wr, .cols_wide,
    .bank_base, .scr_off, .chr_off, .rom_hi, .wide
  );

  vfa_addr #(.OFS_W(OFS_W), .COL_W(COL_W), .ROW_W(ROW_W), .CODE_W(CODE_W),
             .GROW_W(GROW_W), .SPR_W(SPR_W)) i_addr (
    .bank_base, .scr_off, .chr_off, .rom_hi, .wide,
    .kind(req_kind), .col(req_col), .row(req_row), .code(req_code),
    .grow(req_grow), .spr(req_spr), .addr(calc_addr), .rom(calc_rom)
  );

  vfa_out #(.ADDR_W(ADDR_W)) i_out (
    .clk, .rst_n, .in_valid(req_valid), .in_ready(req_ready),
    .in_addr(calc_addr), .in_rom(calc_rom),
    .out_valid(rsp_valid), .out_ready(rsp_ready),
    .out_addr(rsp_addr), .out_rom(rsp_rom)
  );

  p_rom_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_rom) |->
      (rsp_addr[ADDR_W-1:ADDR_W-4] == 4'h9 || rsp_addr[ADDR_W-1:ADDR_W-4] == 4'hD));
endmodule

// File: tb/test_vfa_top.sv
module test_vfa_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bank_wr = 0, base_wr = 0, crom_wr = 0, cols_wr = 0;
  logic [1:0] bank_sel = 0;
  logic [3:0] base_scr = 0;
  logic [2:0] base_chr = 0;
  logic crom_hi = 0, cols_wide = 0;
  logic req_valid = 0, rsp_ready = 1;
  logic [1:0] req_kind = 0;
  logic [6:0] req_col = 0;
  logic [4:0] req_row = 0;
  logic [7:0] req_code = 0;
  logic [2:0] req_grow = 0, req_spr = 0;
  logic req_ready, rsp_valid, rsp_rom;
  logic [15:0] rsp_addr;

  int checks = 0, errors = 0, cyc = 0;

  // behavioural reference state
  int m_bank = 0, m_scr = 0, m_chr = 0, m_addr = 0;
  bit m_rhi = 0, m_wide = 0, m_valid = 0, m_rom = 0;
  string m_tag = "R1";

  always #2 clk = ~clk;

  vfa_top i_vfa_top (.*);

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic void ref_calc(input int k, input int col, input int row, input int code,
                                   input int gr, input int spr,
                                   output int a, output bit r, output string tag);
    int gi;
    gi = (code * 8 + gr) & 'h3FFF;
    r = 0;
    case (k)
      0: begin a = ((col + row * (m_wide ? 80 : 40)) & 'h3FFF) | m_scr | m_bank; tag = "R3"; end
      1: if ((((m_chr >> 12) & 3) == 1) && (((m_bank >> 14) & 1) == 0)) begin
           r = 1; a = (m_rhi ? 'h9000 : 'hD000) + (m_chr & 'h800) + gi; tag = "R5";
         end else begin
           a = ((m_chr | m_bank) + gi) & 'hFFFF; tag = "R6";
         end
      2: begin a = ((m_scr + (m_wide ? 'h7F8 : 'h3F8) + spr) & 'h3FFF) | m_bank; tag = "R7"; end
      default: begin a = ((code * 64 + (col & 63)) & 'h3FFF) | m_bank; tag = "R8"; end
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_bank = 0; m_scr = 0; m_chr = 0; m_rhi = 0; m_wide = 0; m_valid = 0;
    end else begin
      if (req_valid && (!m_valid || rsp_ready)) begin
        ref_calc(req_kind, req_col, req_row, req_code, req_grow, req_spr, m_addr, m_rom, m_tag);
        m_valid = 1;
      end else if (rsp_ready) m_valid = 0;
      if (bank_wr) m_bank = ((~bank_sel) & 3) << 14;
      if (base_wr) begin m_scr = base_scr << 10; m_chr = base_chr << 11; end
      if (crom_wr) m_rhi = crom_hi;
      if (cols_wr) m_wide = cols_wide;
    end
    if (cyc == 100000) begin
      errors++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) if (rst_n) begin
    chk(req_ready == (!m_valid || rsp_ready), "R10", "req_ready", req_ready, !m_valid || rsp_ready);
    chk(rsp_valid == m_valid, "R9", "rsp_valid", rsp_valid, m_valid);
    if (m_valid) begin
      chk(rsp_addr == m_addr[15:0], m_tag, "rsp_addr", rsp_addr, m_addr);
      chk(rsp_rom == m_rom, m_tag, "rsp_rom", rsp_rom, m_rom);
    end
  end

  task automatic wr_bank(input int v);
    @(negedge clk); #1 bank_wr = 1; bank_sel = 2'(v);
    @(negedge clk); #1 bank_wr = 0;
  endtask
  task automatic wr_base(input int s, input int c);
    @(negedge clk); #1 base_wr = 1; base_scr = 4'(s); base_chr = 3'(c);
    @(negedge clk); #1 base_wr = 0;
  endtask
  task automatic wr_crom(input bit v);
    @(negedge clk); #1 crom_wr = 1; crom_hi = v;
    @(negedge clk); #1 crom_wr = 0;
  endtask
  task automatic wr_cols(input bit v);
    @(negedge clk); #1 cols_wr = 1; cols_wide = v;
    @(negedge clk); #1 cols_wr = 0;
  endtask
  task automatic set_req(input int k, input int col, input int row, input int code,
                         input int gr, input int spr);
    req_kind = 2'(k); req_col = 7'(col); req_row = 5'(row);
    req_code = 8'(code); req_grow = 3'(gr); req_spr = 3'(spr);
  endtask
  task automatic do_req(input int k, input int col, input int row, input int code,
                        input int gr, input int spr, input int ea, input bit er, input string tag);
    @(negedge clk); #1 req_valid = 1; set_req(k, col, row, code, gr, spr);
    @(negedge clk);
    chk(rsp_valid == 1'b1, tag, "directed valid", rsp_valid, 1);
    chk(rsp_addr == 16'(ea), tag, "directed addr", rsp_addr, ea);
    chk(rsp_rom == er, tag, "directed rom", rsp_rom, er);
    #1 req_valid = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(rsp_valid == 0, "R1", "reset rsp_valid", rsp_valid, 0);
    chk(req_ready == 1, "R1", "reset req_ready", req_ready, 1);
    do_req(0, 7, 1, 0, 0, 0, 'h002F, 0, "R1");      // zero bases after reset
    wr_bank(0);
    do_req(0, 5, 2, 0, 0, 0, 'hC055, 0, "R2");      // sel 00 -> bank 0xC000
    wr_bank(3);
    wr_cols(1);
    do_req(0, 3, 1, 0, 0, 0, 'h0053, 0, "R4");      // 80 columns
    wr_cols(0);
    do_req(0, 3, 1, 0, 0, 0, 'h002B, 0, "R4");      // 40 columns
    wr_base(0, 2);
    wr_crom(1);
    do_req(1, 0, 0, 'h41, 3, 0, 'h920B, 1, "R5");
    wr_base(0, 3);
    wr_crom(0);
    do_req(1, 0, 0, 'h41, 3, 0, 'hDA0B, 1, "R5");
    wr_bank(1);                                     // bank 0x8000, bit 14 clear
    do_req(1, 0, 0, 'h41, 3, 0, 'hDA0B, 1, "R5");
    wr_bank(0);
    wr_base(0, 2);
    do_req(1, 0, 0, 'h41, 3, 0, 'hD20B, 0, "R6");   // bank bit 14 set -> RAM
    wr_bank(3);
    wr_base(1, 0);
    do_req(2, 0, 0, 0, 0, 2, 'h07FA, 0, "R7");
    wr_cols(1);
    do_req(2, 0, 0, 0, 0, 2, 'h0BFA, 0, "R7");
    wr_cols(0);
    wr_bank(2);
    do_req(3, 5, 0, 'h12, 0, 0, 'h4485, 0, "R8");
    // R11: write and request in the same cycle
    @(negedge clk); #1 bank_wr = 1; bank_sel = 0; req_valid = 1; set_req(0, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk(rsp_addr == 16'h4400, "R11", "old bank used", rsp_addr, 'h4400);
    #1 bank_wr = 0; req_valid = 0;
    do_req(0, 0, 0, 0, 0, 0, 'hC400, 0, "R11");
    // R10: stall
    @(negedge clk); #1 rsp_ready = 0; req_valid = 1; set_req(0, 1, 0, 0, 0, 0);
    @(negedge clk); #1 set_req(0, 9, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_addr == 16'hC401, "R10", "stalled addr", rsp_addr, 'hC401);
      chk(req_ready == 0, "R10", "stalled ready", req_ready, 0);
    end
    #1 rsp_ready = 1;
    @(negedge clk);
    chk(rsp_addr == 16'hC409, "R10", "after stall", rsp_addr, 'hC409);
    #1 req_valid = 0;
    // random phase, compared every cycle by the reference
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk); #1;
      bank_wr = ($urandom % 16) == 0; bank_sel = 2'($urandom);
      base_wr = ($urandom % 16) == 0; base_scr = 4'($urandom); base_chr = 3'($urandom);
      crom_wr = ($urandom % 16) == 0; crom_hi = 1'($urandom);
      cols_wr = ($urandom % 16) == 0; cols_wide = 1'($urandom);
      req_valid = 1'($urandom); rsp_ready = ($urandom % 4) != 0;
      set_req($urandom % 4, $urandom % 80, $urandom % 25, $urandom % 256,
              $urandom % 8, $urandom % 8);
    end
    @(negedge clk); #1 req_valid = 0; rsp_ready = 1;
    bank_wr = 0; base_wr = 0; crom_wr = 0; cols_wr = 0;
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule